// File: doc/BRIEF.md
# Retire Stall Cycle Counter

This block follows a single instruction that a sampling unit has picked out while that instruction sits in a reorder buffer. It produces one stall figure for the sample record. The figure is measured in one of two ways, and the order of two events picks which one applies.

If the instruction finishes execution before it reaches the head of the buffer, the figure counts the cycles it spends waiting for older work to retire. If it reaches the head before it has finished, the figure counts the cycles it occupies the head and so blocks everything younger. A kind flag tells the reader which of the two measurements the count holds.

The control pins are plain one-cycle indications, each paired with a tag. The result is a strobe with no back-pressure: `rec_done` pulses once, and `stall_cycles` and `stall_kind` stay readable until the next start, so a consumer may collect them at leisure. A squash that removes the tracked entry drops the measurement and raises no strobe. The reorder buffer holds 2^TAG_W entries.

Top module: `retire_stall_counter`

## Requirements
- R1: The result is a single count with a kind flag. Kind 1 means completion came first and kind 0 means reaching the head came first. The kind is fixed once decided and does not change for the rest of that measurement.
- R2: When completion comes first, the count equals the number of clock edges from the completion edge to the retire edge, counting the retire edge and not counting the completion edge.
- R3: When reaching the head comes first, the count equals the number of edges from the first edge at which `head_valid` is high with `head_tag` equal to the tracked tag, up to the retire edge, counted in the same way as R2.
- R4: If completion and reaching the head are seen at the same edge, the measurement is the completion-first kind.
- R5: A retire of the tracked tag seen before either event has been recorded ends the measurement with count 0 and kind 1.
- R6: `rec_done` is high for exactly one cycle, following the edge at which `ret_valid` is sampled with the tracked tag. From then on, count and kind hold their values until the next start.
- R7: The count saturates at all ones (2^CNT_W-1) and never wraps.
- R8: An edge with `smp_start` high clears count and kind to 0 and begins tracking `smp_tag`, replacing any measurement in progress. Events presented at that same edge are ignored.
- R9: Each entry's age is (tag − `head_tag`) mod 2^TAG_W. A squash removes every entry whose age is at or above the age of `squash_tag`. If the tracked entry is removed, the measurement is aborted: no `rec_done`, and count and kind are cleared to 0. A squash takes priority over a retire at the same edge.
- R10: Completions and head indications for other tags have no effect, and neither does a retire while no measurement is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_start | input | 1 | Begin tracking a newly picked instruction |
| smp_tag | input | TAG_W | Buffer tag of the picked instruction |
| wb_valid | input | 1 | An instruction finished execution this cycle |
| wb_tag | input | TAG_W | Tag of the finished instruction |
| head_valid | input | 1 | The buffer holds at least one entry |
| head_tag | input | TAG_W | Tag of the oldest entry |
| ret_valid | input | 1 | The oldest entry retires this cycle |
| ret_tag | input | TAG_W | Tag of the retiring entry |
| squash_valid | input | 1 | Squash of young entries this cycle |
| squash_tag | input | TAG_W | Oldest tag removed by the squash |
| stall_cycles | output | CNT_W | Measured stall count |
| stall_kind | output | 1 | 1 = completion first, 0 = head first |
| rec_done | output | 1 | One-cycle strobe: result ready |

## Verification
Every result is a register loaded at the edge that samples its cause. The strobe, count and kind for a retire at edge r can therefore be read in the half cycle after edge r, and the strobe must be low again after edge r+1. The bench drives each edge's inputs on the preceding falling edge and samples on the falling edge that follows, so each check looks at the state one register stage after its stimulus. Expected counts are worked out as the retire edge index minus the deciding event's edge index, measured from the start edge.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TRACK = 2'd1,
    ST_WAIT  = 2'd2,
    ST_HOLD  = 2'd3
  } rs_state_e;
endpackage

// File: rtl/rs_tag_match.sv
module rs_tag_match #(
  parameter int TAG_W = 6
) (
  input  logic [TAG_W-1:0] trk_tag,
  input  logic             wb_valid,
  input  logic [TAG_W-1:0] wb_tag,
  input  logic             head_valid,
  input  logic [TAG_W-1:0] head_tag,
  input  logic             ret_valid,
  input  logic [TAG_W-1:0] ret_tag,
  input  logic             squash_valid,
  input  logic [TAG_W-1:0] squash_tag,
  output logic             hit_wb,
  output logic             hit_head,
  output logic             hit_ret,
  output logic             hit_squash
);
  logic [TAG_W-1:0] trk_age;
  logic [TAG_W-1:0] cut_age;

  always_comb begin
    trk_age    = trk_tag - head_tag;
    cut_age    = squash_tag - head_tag;
    hit_wb     = wb_valid && (wb_tag == trk_tag);
    hit_head   = head_valid && (head_tag == trk_tag);
    hit_ret    = ret_valid && (ret_tag == trk_tag);
    hit_squash = squash_valid && (trk_age >= cut_age);
  end
endmodule

// File: rtl/rs_sat_counter.sv
module rs_sat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (clr)            cnt <= '0;
    else if (en && cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !clr) |=> (cnt == CNT_MAX)); // R7
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0)); // R8
endmodule

// File: rtl/rs_ctrl.sv
module rs_ctrl
  import rs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic smp_start,
  input  logic hit_wb,
  input  logic hit_head,
  input  logic hit_ret,
  input  logic hit_squash,
  output logic cnt_clr,
  output logic cnt_en,
  output logic kind,
  output logic done
);
  rs_state_e state_q, state_n;
  logic      kind_n, done_n, abort;

  always_comb begin
    state_n = state_q;
    kind_n  = kind;
    done_n  = 1'b0;
    cnt_clr = 1'b0;
    cnt_en  = 1'b0;
    abort   = 1'b0;
    if (smp_start) begin
      state_n = ST_TRACK;
      kind_n  = 1'b0;
      cnt_clr = 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: ;
        ST_TRACK: begin
          if (hit_squash) begin
            abort = 1'b1;
          end else if (hit_ret) begin
            state_n = ST_IDLE;
            kind_n  = 1'b1;
            done_n  = 1'b1;
          end else if (hit_wb) begin
            state_n = ST_WAIT;
            kind_n  = 1'b1;
          end else if (hit_head) begin
            state_n = ST_HOLD;
            kind_n  = 1'b0;
          end
        end
        ST_WAIT, ST_HOLD: begin
          if (hit_squash) begin
            abort = 1'b1;
          end else begin
            cnt_en = 1'b1;
            if (hit_ret) begin
              state_n = ST_IDLE;
              done_n  = 1'b1;
            end
          end
        end
        default: state_n = ST_IDLE;
      endcase
      if (abort) begin
        state_n = ST_IDLE;
        kind_n  = 1'b0;
        cnt_clr = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind    <= 1'b0;
      done    <= 1'b0;
    end else begin
      state_q <= state_n;
      kind    <= kind_n;
      done    <= done_n;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_KIND_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_WAIT || state_q == ST_HOLD) && !smp_start && !hit_squash)
      |=> $stable(kind)); // R1
  AST_ABORT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!done && !kind)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !smp_start) |=> !done); // R10
endmodule

// File: rtl/retire_stall_counter.sv
module retire_stall_counter #(
  parameter int TAG_W = 6,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_start,
  input  logic [TAG_W-1:0] smp_tag,
  input  logic             wb_valid,
  input  logic [TAG_W-1:0] wb_tag,
  input  logic             head_valid,
  input  logic [TAG_W-1:0] head_tag,
  input  logic             ret_valid,
  input  logic [TAG_W-1:0] ret_tag,
  input  logic             squash_valid,
  input  logic [TAG_W-1:0] squash_tag,
  output logic [CNT_W-1:0] stall_cycles,
  output logic             stall_kind,
  output logic             rec_done
);
  logic [TAG_W-1:0] trk_tag;
  logic hit_wb, hit_head, hit_ret, hit_squash;
  logic cnt_clr, cnt_en;

  always_ff @(posedge clk) begin
    if (!rst_n)         trk_tag <= '0;
    else if (smp_start) trk_tag <= smp_tag;
  end

  rs_tag_match #(.TAG_W(TAG_W)) u_match (
    .trk_tag(trk_tag), .wb_valid(wb_valid), .wb_tag(wb_tag),
    .head_valid(head_valid), .head_tag(head_tag),
    .ret_valid(ret_valid), .ret_tag(ret_tag),
    .squash_valid(squash_valid), .squash_tag(squash_tag),
    .hit_wb(hit_wb), .hit_head(hit_head), .hit_ret(hit_ret), .hit_squash(hit_squash)
  );

  rs_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .smp_start(smp_start),
    .hit_wb(hit_wb), .hit_head(hit_head), .hit_ret(hit_ret), .hit_squash(hit_squash),
    .cnt_clr(cnt_clr), .cnt_en(cnt_en), .kind(stall_kind), .done(rec_done)
  );

  rs_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .en(cnt_en), .cnt(stall_cycles)
  );

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    smp_start |=> (stall_cycles == '0 && !stall_kind && !rec_done)); // R8
  AST_HOLD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_done && !smp_start) |=> $stable(stall_cycles)); // R6
endmodule

// File: tb/sim_retire_stall_counter.sv
`timescale 1ns/1ps
module sim_retire_stall_counter;
  localparam int TAG_W = 6;
  localparam int CNT_W = 8;
  localparam real HALF = 2.5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_start = 0, wb_valid = 0, head_valid = 0, ret_valid = 0, squash_valid = 0;
  logic [TAG_W-1:0] smp_tag = '0, wb_tag = '0, head_tag = '0, ret_tag = '0, squash_tag = '0;
  logic [CNT_W-1:0] stall_cycles;
  logic stall_kind, rec_done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(HALF) clk = ~clk;

  retire_stall_counter #(.TAG_W(TAG_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_start(smp_start), .smp_tag(smp_tag),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .head_valid(head_valid), .head_tag(head_tag),
    .ret_valid(ret_valid), .ret_tag(ret_tag), .squash_valid(squash_valid),
    .squash_tag(squash_tag), .stall_cycles(stall_cycles), .stall_kind(stall_kind),
    .rec_done(rec_done)
  );

  typedef struct packed {
    int c; int o; int r; int cnt; int kind;
  } vec_t;
  // edges after start: completion, head, retire; expected count and kind
  localparam vec_t VECS [0:5] = '{
    '{2, 5, 6, 4, 1},
    '{6, 2, 7, 5, 0},
    '{3, 3, 4, 1, 1},
    '{1, 1, 1, 0, 1},
    '{1, 8, 10, 9, 1},
    '{9, 1, 12, 11, 0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input bit s, input int st, input bit w, input int wt,
                     input int ht, input bit r, input int rt, input bit q, input int qt);
    @(negedge clk);
    smp_start = s; smp_tag = st[TAG_W-1:0];
    wb_valid = w; wb_tag = wt[TAG_W-1:0];
    head_valid = 1'b1; head_tag = ht[TAG_W-1:0];
    ret_valid = r; ret_tag = rt[TAG_W-1:0];
    squash_valid = q; squash_tag = qt[TAG_W-1:0];
  endtask

  task automatic quiet();
    @(negedge clk);
    smp_start = 0; wb_valid = 0; ret_valid = 0; squash_valid = 0;
  endtask

  initial begin
    #(HALF * 2 * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset cnt", stall_cycles, 0);
    chk("reset kind", stall_kind, 0);
    chk("reset done", rec_done, 0);

    // table of vectors: R2 R3 R4 R5 R6
    for (int i = 0; i < 6; i++) begin
      int t;
      t = 16 + i;
      for (int k = 0; k <= VECS[i].r; k++)
        cyc(k == 0, t, (k > 0) && (k == VECS[i].c), t,
            (k >= VECS[i].o) ? t : t - 1, k == VECS[i].r, t, 0, 0);
      quiet();
      chk("R6 done", rec_done, 1);
      chk("R2/R3 count", stall_cycles, VECS[i].cnt);
      chk("R1/R4 kind", stall_kind, VECS[i].kind);
      @(negedge clk);
      chk("R6 single pulse", rec_done, 0);
      chk("R6 hold", stall_cycles, VECS[i].cnt);
    end

    // R8: events at the start edge ignored
    cyc(1, 5, 1, 5, 4, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 4, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 4, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 5, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 5, 1, 5, 0, 0);
    quiet();
    chk("R8 kind", stall_kind, 0);
    chk("R8 count", stall_cycles, 1);

    // R8: restart replaces measurement in progress
    cyc(1, 3, 0, 0, 2, 0, 0, 0, 0);
    cyc(0, 0, 1, 3, 2, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 2, 0, 0, 0, 0);
    quiet();
    chk("R8 counting before restart", stall_cycles, 1);
    cyc(1, 20, 0, 0, 19, 0, 0, 0, 0);
    quiet();
    chk("R8 restart clears", stall_cycles, 0);
    chk("R8 restart done low", rec_done, 0);
    cyc(0, 0, 0, 0, 20, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 20, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 20, 1, 20, 0, 0);
    quiet();
    chk("R8 restart kind", stall_kind, 0);
    chk("R8 restart count", stall_cycles, 2);

    // R10: other tags ignored, retire while idle ignored
    cyc(1, 7, 0, 0, 6, 0, 0, 0, 0);
    cyc(0, 0, 1, 8, 6, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 7, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 7, 0, 0, 0, 0);
    cyc(0, 0, 1, 7, 7, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 7, 1, 7, 0, 0);
    quiet();
    chk("R10 kind", stall_kind, 0);
    chk("R10 count", stall_cycles, 3);
    cyc(0, 0, 0, 0, 7, 1, 7, 0, 0);
    quiet();
    chk("R10 idle retire no done", rec_done, 0);
    chk("R10 idle retire count", stall_cycles, 3);

    // R9: squash removes tracked entry
    cyc(1, 10, 0, 0, 5, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 5, 0, 0, 0, 0);
    cyc(0, 0, 1, 10, 5, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 5, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 5, 0, 0, 1, 8);
    quiet();
    chk("R9 abort count", stall_cycles, 0);
    chk("R9 abort kind", stall_kind, 0);
    chk("R9 abort done", rec_done, 0);
    cyc(0, 0, 0, 0, 10, 1, 10, 0, 0);
    quiet();
    chk("R9 no done after abort", rec_done, 0);

    // R9: squash younger than tracked keeps it
    cyc(1, 4, 0, 0, 2, 0, 0, 0, 0);
    cyc(0, 0, 1, 4, 2, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 2, 0, 0, 1, 9);
    cyc(0, 0, 0, 0, 4, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 4, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 4, 1, 4, 0, 0);
    quiet();
    chk("R9 kept done", rec_done, 1);
    chk("R9 kept count", stall_cycles, 4);

    // R9: age wraps around the tag space
    cyc(1, 2, 0, 0, 60, 0, 0, 0, 0);
    cyc(0, 0, 1, 2, 60, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 60, 0, 0, 1, 62);
    cyc(0, 0, 0, 0, 2, 1, 2, 0, 0);
    quiet();
    chk("R9 wrap abort done", rec_done, 0);
    chk("R9 wrap abort count", stall_cycles, 0);

    // R9: squash beats retire at same edge
    cyc(1, 30, 0, 0, 30, 0, 0, 0, 0);
    cyc(0, 0, 1, 30, 30, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 30, 1, 30, 1, 30);
    quiet();
    chk("R9 priority done", rec_done, 0);

    // R7: saturation
    cyc(1, 40, 0, 0, 39, 0, 0, 0, 0);
    cyc(0, 0, 1, 40, 39, 0, 0, 0, 0);
    for (int k = 2; k < 300; k++) cyc(0, 0, 0, 0, (k > 100) ? 40 : 39, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 40, 1, 40, 0, 0);
    quiet();
    chk("R7 saturated count", stall_cycles, 255);
    chk("R7 kind", stall_kind, 1);
    chk("R7 done", rec_done, 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule